// File: doc/BRIEF.md
# Four-channel single-bin IQ demodulator

This block takes four ADC sample streams that advance together, one per receiver, each carrying a tone at a known intermediate frequency. A single numerically controlled oscillator produces one sine and cosine pair for all four lanes. Each accepted sample is weighted by both, and the products are summed per lane over a window of a programmed length. The result is one Fourier bin per channel, with a phase reference that all four receivers share, so ratios between channels keep their relative phase.

The user writes a frequency word and a sample count, then pulses start. Samples are taken only while the input valid flag is high, so the measurement length is set by the count of accepted samples and not by clock cycles. When the window closes, a sequential restoring divider turns each of the eight sums into an average. A single strobe then presents all eight averages together. A longer window narrows the effective IF bandwidth.

Top module: `iq_bin_demod`

## Requirements
- R1: One `s_valid` qualifies all four lanes together. Lane c is `s_data[c*12 +: 12]`, a 12-bit two's complement value. All lanes use the same oscillator phase for the same sample.
- R2: The 32-bit phase accumulator is cleared by an accepted start and advances by the latched frequency word after each accepted sample. The table index is phase bits [31:22], the sine is round(32767·sin(2πk/1024)) and the cosine is the sine at index k+256 mod 1024. Rounding is half away from zero.
- R3: Per lane, the I sum is Σx·cos and the Q sum is Σx·sin, held in 56-bit signed accumulators that cannot overflow for any count below 2^24.
- R4: Each result is its sum divided by the sample count, truncated toward zero, as a 28-bit signed value. Lane c of I is `res_i[c*28 +: 28]` and lane c of Q is `res_q[c*28 +: 28]`.
- R5: `done` is high for exactly one cycle. All eight results change in that cycle and hold until the next `done`.
- R6: `done` rises 58 cycles (accumulator width plus two) after the clock edge that accepts the last sample, once every quotient is complete.
- R7: A start pulse while a measurement is in progress has no effect. The window keeps its original count and frequency.
- R8: A start with a count of zero gives `done` on the second edge after start, with all results zero.
- R9: Cycles with `s_valid` low neither add to the sums nor advance the phase, whatever `s_data` carries.
- R10: After reset, `done` is low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a measurement (accepted only when idle) |
| freq_word | input | 32 | Phase increment per accepted sample |
| num_samples | input | 24 | Window length in accepted samples |
| s_valid | input | 1 | Sample strobe for all four lanes |
| s_data | input | 48 | Four packed 12-bit signed samples |
| done | output | 1 | One-cycle strobe, results updated |
| res_i | output | 112 | Four packed 28-bit signed I averages |
| res_q | output | 112 | Four packed 28-bit signed Q averages |

## Verification
A phase accumulator that is wrong or not cleared changes every later product, so the averages for all four lanes move away from the values computed in the bench on the very next strobe. Accepted samples that are miscounted show up two ways: `done` arrives too early or too late, or the divide uses the wrong count. A divider fault, such as a bad bit order or a missed restore, corrupts the quotients as soon as they are presented. A zero count and a maximum-magnitude constant input test the sign handling and the headroom of the accumulators.

// File: rtl/iq_bin_demod.sv
module iq_bin_demod #(
  parameter int CH = 4,
  parameter int SW = 12,
  parameter int PW = 32,
  parameter int LW = 10,
  parameter int AW = 16,
  parameter int NW = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [PW-1:0]            freq_word,
  input  logic [NW-1:0]            num_samples,
  input  logic                     s_valid,
  input  logic [CH*SW-1:0]         s_data,
  output logic                     done,
  output logic [CH*(SW+AW)-1:0]    res_i,
  output logic [CH*(SW+AW)-1:0]    res_q
);
  localparam int QW    = SW + AW;
  localparam int ACCW  = SW + AW + NW + 4;
  localparam int LUT_N = 1 << LW;
  localparam int BCW   = $clog2(ACCW);

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_LOAD, S_DIV, S_FIN} st_t;

  st_t            st;
  logic [PW-1:0]  ph, fw_q;
  logic [NW-1:0]  lim, seen;
  logic [BCW-1:0] bitc;

  logic signed [AW-1:0] rom [LUT_N];
  initial begin
    real r;
    for (int k = 0; k < LUT_N; k++) begin
      r = real'((1 << (AW-1)) - 1) * $sin(2.0 * 3.14159265358979 * k / LUT_N);
      rom[k] = AW'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
    end
  end

  logic [LW-1:0] sidx, cidx;
  logic signed [AW-1:0] sin_v, cos_v;
  assign sidx  = ph[PW-1 -: LW];
  assign cidx  = sidx + LW'(LUT_N / 4);
  assign sin_v = rom[sidx];
  assign cos_v = rom[cidx];

  logic go, take;
  assign go   = (st == S_IDLE) && start;
  assign take = (st == S_ACC) && s_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      ph   <= '0;
      fw_q <= '0;
      lim  <= '0;
      seen <= '0;
      bitc <= '0;
      done <= 1'b0;
    end else begin
      done <= (st == S_FIN);
      case (st)
        S_IDLE: if (start) begin
          ph   <= '0;
          fw_q <= freq_word;
          lim  <= num_samples;
          seen <= '0;
          st   <= (num_samples == '0) ? S_FIN : S_ACC;
        end
        S_ACC: if (s_valid) begin
          ph   <= ph + fw_q;
          seen <= seen + NW'(1);
          if (seen == lim - NW'(1)) st <= S_LOAD;
        end
        S_LOAD: begin
          bitc <= '0;
          st   <= S_DIV;
        end
        S_DIV: begin
          bitc <= bitc + BCW'(1);
          if (bitc == BCW'(ACCW - 1)) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < 2*CH; k++) begin : g_lane
    localparam int CHN  = k % CH;
    localparam bit IS_Q = (k >= CH);

    logic signed [SW-1:0]   x;
    logic signed [AW-1:0]   cf;
    logic signed [QW-1:0]   prod;
    logic signed [ACCW-1:0] acc;
    logic [ACCW-1:0]        dvd;
    logic [NW-1:0]          rem;
    logic [NW:0]            r2;
    logic                   ge, neg;
    logic [QW-1:0]          rq;

    assign x    = s_data[CHN*SW +: SW];
    assign cf   = IS_Q ? sin_v : cos_v;
    assign prod = QW'(x) * QW'(cf);
    assign r2   = {rem, dvd[ACCW-1]};
    assign ge   = r2 >= {1'b0, lim};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc <= '0;
        dvd <= '0;
        rem <= '0;
        neg <= 1'b0;
        rq  <= '0;
      end else if (go) begin
        acc <= '0;
        dvd <= '0;
        rem <= '0;
        neg <= 1'b0;
      end else if (take) begin
        acc <= acc + ACCW'(prod);
      end else if (st == S_LOAD) begin
        neg <= acc[ACCW-1];
        dvd <= acc[ACCW-1] ? -acc : acc;
        rem <= '0;
      end else if (st == S_DIV) begin
        rem <= ge ? NW'(r2 - {1'b0, lim}) : r2[NW-1:0];
        dvd <= {dvd[ACCW-2:0], ge};
      end else if (st == S_FIN) begin
        rq  <= neg ? -dvd[QW-1:0] : dvd[QW-1:0];
      end
    end

    if (IS_Q) begin : g_q
      assign res_q[CHN*QW +: QW] = rq;
    end else begin : g_i
      assign res_i[CHN*QW +: QW] = rq;
    end
  end
endmodule

// File: rtl/iq_bin_demod_chk.sv
module iq_bin_demod_chk #(
  parameter int CH = 4,
  parameter int PW = 32,
  parameter int NW = 24,
  parameter int QW = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [NW-1:0]    num_samples,
  input logic             done,
  input logic [CH*QW-1:0] res_i,
  input logic [CH*QW-1:0] res_q,
  input logic [2:0]       st,
  input logic [PW-1:0]    ph,
  input logic [NW-1:0]    lim
);
  p_phase_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && start) |=> (ph == '0));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == 3'd4));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 3'd0 && start) |=> $stable(lim));

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && start && num_samples == '0) |-> ##2 (done && res_i == '0 && res_q == '0));
endmodule

bind iq_bin_demod iq_bin_demod_chk #(.CH(CH), .PW(PW), .NW(NW), .QW(SW + AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .num_samples(num_samples), .done(done),
  .res_i(res_i), .res_q(res_q), .st(st), .ph(ph), .lim(lim)
);

// File: tb/iq_bin_demod_tb_top.sv
module iq_bin_demod_tb_top;
  localparam int CH = 4, SW = 12, PW = 32, LW = 10, AW = 16, NW = 24;
  localparam int QW = SW + AW, ACCW = SW + AW + NW + 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, s_valid, done;
  logic [PW-1:0] freq_word;
  logic [NW-1:0] num_samples;
  logic [CH*SW-1:0] s_data;
  logic [CH*QW-1:0] res_i, res_q;

  iq_bin_demod dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_word(freq_word),
    .num_samples(num_samples), .s_valid(s_valid), .s_data(s_data),
    .done(done), .res_i(res_i), .res_q(res_q)
  );

  int n_chk = 0, n_fail = 0, cval = 0;
  longint si [CH];
  longint sq [CH];

  function automatic longint tbl(int k);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * (k % 1024) / 1024.0);
    return longint'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
  endfunction

  function automatic longint lane(logic [CH*QW-1:0] v, int c);
    logic signed [QW-1:0] t;
    t = v[c*QW +: QW];
    return longint'(t);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_near(string req, longint act, longint exp, longint tol);
    n_chk++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] fw, input int n, input int mode,
                     input int glitch_at, input int gapmax);
    logic [31:0] phm;
    int lat;
    logic [CH*QW-1:0] hi, hq;
    phm = '0;
    for (int c = 0; c < CH; c++) begin si[c] = 0; sq[c] = 0; end
    @(negedge clk);
    freq_word = fw; num_samples = NW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      check("R8 no early done", longint'(done), 0);
      @(negedge clk);
      check("R8 done", longint'(done), 1);
      check("R8 res_i zero", longint'(res_i == '0), 1);
      check("R8 res_q zero", longint'(res_q == '0), 1);
      return;
    end
    for (int j = 0; j < n; j++) begin
      int gaps;
      gaps = (gapmax > 0) ? int'($urandom % (gapmax + 1)) : 0;
      for (int g = 0; g < gaps; g++) begin
        s_valid = 1'b0;
        s_data = {$urandom, $urandom};
        @(negedge clk);
      end
      for (int c = 0; c < CH; c++) begin
        int x;
        int idx;
        if (mode == 0) x = int'($urandom % 4096) - 2048;
        else if (mode == 1) x = $rtoi(1500.0 * $cos(2.0 * 3.14159265358979 *
                                 (real'(phm) / 4294967296.0) + 0.7 * c));
        else x = cval;
        s_data[c*SW +: SW] = SW'(x);
        idx = int'(phm >> 22);
        si[c] += longint'(x) * tbl(idx + 256);
        sq[c] += longint'(x) * tbl(idx);
      end
      s_valid = 1'b1;
      phm = phm + fw;
      if (j == glitch_at) begin
        start = 1'b1;
        num_samples = NW'($urandom % 50 + 1);
        freq_word = $urandom;
      end
      @(negedge clk);
      start = 1'b0;
    end
    s_valid = 1'b0;
    lat = 0;
    while (!done && lat < ACCW + 20) begin
      @(negedge clk);
      lat++;
    end
    check("R6 latency", lat, ACCW + 2);
    for (int c = 0; c < CH; c++) begin
      check($sformatf("R4 I lane %0d", c), lane(res_i, c), si[c] / n);
      check($sformatf("R4 Q lane %0d", c), lane(res_q, c), sq[c] / n);
    end
    hi = res_i; hq = res_q;
    @(negedge clk);
    check("R5 done one cycle", longint'(done), 0);
    repeat (3) @(negedge clk);
    check("R5 results held", longint'(res_i == hi && res_q == hq), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; start = 1'b0; s_valid = 1'b0;
    freq_word = '0; num_samples = '0; s_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done low", longint'(done), 0);
    check("R10 res_i zero", longint'(res_i == '0), 1);
    check("R10 res_q zero", longint'(res_q == '0), 1);

    // R1 R2 R3: tone sanity, period 16 samples, lane phases differ
    run(32'h1000_0000, 1600, 1, -1, 0);
    check_near("R3 tone I lane0 magnitude", lane(res_i, 0), 24575250, 150000);
    check_near("R3 tone Q lane0 near zero", lane(res_q, 0), 0, 150000);
    check_near("R1 tone I lane2 rotated", lane(res_i, 2),
               $rtoi(24575250.0 * $cos(1.4)), 200000);

    // R9: random data with idle gaps carrying garbage
    run($urandom, 300, 0, -1, 3);

    // R7: restart attempts inside the window
    for (int t = 0; t < 6; t++)
      run($urandom, int'($urandom % 1500) + 2, 0, int'($urandom % 2), 2);
    run($urandom, 400, 0, 200, 1);

    run($urandom, 1, 0, -1, 0);
    run($urandom, 0, 0, -1, 0);

    // R3 R4: maximum magnitude, negative sign
    cval = -2048;
    run(32'h0, 60000, 2, -1, 0);
    check("R3 max I", lane(res_i, 3), -2048 * 32767);
    check("R3 max Q", lane(res_q, 3), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule